// File: doc/BRIEF.md
# Configurable Bitwise Logic Function Unit

This block is a combinational logic unit. It takes two operands of the same width and a 3-bit function code. It returns a result of that same width, and each result bit is computed from the two operand bits at the same position. The function code picks one of eight two-input functions: the constants one and zero, plus OR, AND, NAND, NOR, XOR and XNOR.

Each bit position is built as an 8-to-1 selector in sum-of-minterms form. A shared decoder turns the function code into eight minterm lines, with the most significant code bit as the high-order select. Each output bit is then the OR, over all k, of minterm k ANDed with candidate k for that bit. There is no clock and no storage, so the result follows the inputs within the same evaluation. A function code that carries X or Z drives the whole result to X in four-state simulation.

Top module: `lfu_logic_unit`

## Requirements
- R1: The result has exactly WIDTH bits. WIDTH is a parameter with a default of 8, and both operands have the same width.
- R2: Function code 3'b000 drives every result bit to 1, whatever the operand values.
- R3: Function code 3'b111 drives every result bit to 0, whatever the operand values.
- R4: Function code 3'b001 gives the bitwise OR of the two operands.
- R5: Function code 3'b101 gives the bitwise AND of the two operands.
- R6: Function code 3'b010 gives the bitwise NAND of the two operands.
- R7: Function code 3'b110 gives the bitwise NOR of the two operands.
- R8: Function code 3'b011 gives the bitwise XOR of the two operands.
- R9: Function code 3'b100 gives the bitwise XNOR of the two operands.
- R10: Result bit i depends only on operand bits i. A single set operand bit at position j under OR changes result bit j and no other bit.
- R11: For every known function code, exactly one of the eight minterm lines is active. It is the line whose index equals the code read as an unsigned number with bit 2 as MSB, and each result bit equals candidate number (code) for that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| func_sel | input | 3 | Function code; bit 2 is the most significant select |
| result | output | WIDTH | Bitwise function of the operands chosen by func_sel |

## Verification
The bench builds two copies of the unit. One copy uses WIDTH=4, which makes the full space of 16 x 16 operand pairs under all eight codes small enough to sweep exhaustively, so every truth-table row is hit in every bit lane. The other copy keeps the default WIDTH=8. It is driven with all-zero and all-one corners, single-bit walking patterns that expose cross-lane leakage, and a run of pseudo-random operand pairs from a linear feedback shift register.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

  localparam int unsigned LFU_SEL_W     = 3;
  localparam int unsigned LFU_NUM_CODES = 1 << LFU_SEL_W;

  typedef enum logic [LFU_SEL_W-1:0] {
    LFU_ONE  = 3'd0,
    LFU_OR   = 3'd1,
    LFU_NAND = 3'd2,
    LFU_XOR  = 3'd3,
    LFU_XNOR = 3'd4,
    LFU_AND  = 3'd5,
    LFU_NOR  = 3'd6,
    LFU_ZERO = 3'd7
  } lfu_op_e;

  // All eight candidate results for one bit pair, indexed by function code.
  function automatic logic [LFU_NUM_CODES-1:0] lfu_cand_bit(input logic a, input logic b);
    logic [LFU_NUM_CODES-1:0] c;
    c[LFU_ONE]  = 1'b1;
    c[LFU_OR]   = a | b;
    c[LFU_NAND] = ~(a & b);
    c[LFU_XOR]  = a ^ b;
    c[LFU_XNOR] = ~(a ^ b);
    c[LFU_AND]  = a & b;
    c[LFU_NOR]  = ~(a | b);
    c[LFU_ZERO] = 1'b0;
    return c;
  endfunction

  // Minterm k of the select word: one only when sel equals k.
  function automatic logic lfu_minterm(input logic [LFU_SEL_W-1:0] sel, input int unsigned k);
    logic m;
    m = 1'b1;
    for (int unsigned s = 0; s < LFU_SEL_W; s++) begin
      m = m & (((k >> s) & 1) != 0 ? sel[s] : ~sel[s]);
    end
    return m;
  endfunction

endpackage

// File: rtl/lfu_minterm_decode.sv
module lfu_minterm_decode
  import lfu_pkg::*;
(
  input  logic [LFU_SEL_W-1:0]     sel,
  output logic [LFU_NUM_CODES-1:0] minterm
);

  for (genvar k = 0; k < LFU_NUM_CODES; k++) begin : g_mt
    always_comb begin
      if ($isunknown(sel)) minterm[k] = 1'bx;
      else                 minterm[k] = lfu_minterm(sel, k);
    end
  end

  always_comb begin
    if (!$isunknown(sel)) begin
      p_one_minterm_r11: assert ($countones(minterm) == 1)
        else $error("R11: minterm lines %b not one-hot for sel %b", minterm, sel);
    end
  end

endmodule

// File: rtl/lfu_candidate_gen.sv
module lfu_candidate_gen
  import lfu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]                    a,
  input  logic [WIDTH-1:0]                    b,
  output logic [WIDTH-1:0][LFU_NUM_CODES-1:0] cand
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign cand[i] = lfu_cand_bit(a[i], b[i]);
  end

endmodule

// File: rtl/lfu_sop_mux.sv
module lfu_sop_mux
  import lfu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0][LFU_NUM_CODES-1:0] cand,
  input  logic [LFU_NUM_CODES-1:0]            minterm,
  output logic [WIDTH-1:0]                    y
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic [LFU_NUM_CODES-1:0] term;
    for (genvar k = 0; k < LFU_NUM_CODES; k++) begin : g_term
      assign term[k] = minterm[k] & cand[i][k];
    end
    assign y[i] = |term;
  end

endmodule

// File: rtl/lfu_logic_unit.sv
module lfu_logic_unit
  import lfu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]     opnd_a,
  input  logic [WIDTH-1:0]     opnd_b,
  input  logic [LFU_SEL_W-1:0] func_sel,
  output logic [WIDTH-1:0]     result
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [LFU_NUM_CODES-1:0]            sel_minterm;
  logic [WIDTH-1:0][LFU_NUM_CODES-1:0] lane_cand;

  lfu_minterm_decode i_decode (
    .sel     (func_sel),
    .minterm (sel_minterm)
  );

  lfu_candidate_gen #(.WIDTH(WIDTH)) i_cand (
    .a    (opnd_a),
    .b    (opnd_b),
    .cand (lane_cand)
  );

  lfu_sop_mux #(.WIDTH(WIDTH)) i_mux (
    .cand    (lane_cand),
    .minterm (sel_minterm),
    .y       (result)
  );

  always_comb begin
    if (!$isunknown({func_sel, opnd_a, opnd_b})) begin
      p_const_one_r2: assert (func_sel != LFU_ONE || result == ALL_ONES)
        else $error("R2: result %h", result);
      p_const_zero_r3: assert (func_sel != LFU_ZERO || result == '0)
        else $error("R3: result %h", result);
      p_or_r4: assert (func_sel != LFU_OR || result == (opnd_a | opnd_b))
        else $error("R4: result %h", result);
      p_and_r5: assert (func_sel != LFU_AND || result == (opnd_a & opnd_b))
        else $error("R5: result %h", result);
      p_nand_r6: assert (func_sel != LFU_NAND || result == ~(opnd_a & opnd_b))
        else $error("R6: result %h", result);
      p_nor_r7: assert (func_sel != LFU_NOR || result == ~(opnd_a | opnd_b))
        else $error("R7: result %h", result);
      p_xor_r8: assert (func_sel != LFU_XOR || result == (opnd_a ^ opnd_b))
        else $error("R8: result %h", result);
      p_xnor_r9: assert (func_sel != LFU_XNOR || result == ~(opnd_a ^ opnd_b))
        else $error("R9: result %h", result);
      p_minterm_index_r11: assert (sel_minterm[func_sel] == 1'b1)
        else $error("R11: minterm %b for sel %b", sel_minterm, func_sel);
      for (int i = 0; i < WIDTH; i++) begin
        p_lane_pick_r11: assert (result[i] == lane_cand[i][func_sel])
          else $error("R11: lane %0d mismatch", i);
      end
    end
  end

endmodule

// File: tb/test_lfu_logic_unit.sv
module test_lfu_logic_unit;

  localparam int W4 = 4;
  localparam int W8 = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [W4-1:0] a4, b4, y4;
  logic [W8-1:0] a8, b8, y8;
  logic [2:0]    s4, s8;

  lfu_logic_unit #(.WIDTH(W4)) i_lfu_logic_unit (
    .opnd_a(a4), .opnd_b(b4), .func_sel(s4), .result(y4));

  lfu_logic_unit #(.WIDTH(W8)) i_lfu_logic_unit_w8 (
    .opnd_a(a8), .opnd_b(b8), .func_sel(s8), .result(y8));

  // Reference: per-bit value from the truth table of each code,
  // built by counting set operand bits (0, 1 or 2).
  function automatic logic [W8-1:0] ref_fn(input logic [2:0] op,
                                           input logic [W8-1:0] a,
                                           input logic [W8-1:0] b);
    logic [W8-1:0] r;
    for (int i = 0; i < W8; i++) begin
      int n;
      n = int'(a[i]) + int'(b[i]);
      case (op)
        3'd0: r[i] = 1'b1;           // R2
        3'd1: r[i] = (n >= 1);       // R4
        3'd2: r[i] = (n < 2);        // R6
        3'd3: r[i] = (n == 1);       // R8
        3'd4: r[i] = (n != 1);       // R9
        3'd5: r[i] = (n == 2);       // R5
        3'd6: r[i] = (n == 0);       // R7
        default: r[i] = 1'b0;        // R3
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3: return "R8";
      3'd4: return "R9";
      3'd5: return "R5";
      3'd6: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [W8-1:0] act, input logic [W8-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [W8-1:0] lfsr;
    a4 = '0; b4 = '0; s4 = 3'd0;
    a8 = '0; b8 = '0; s8 = 3'd0;
    @(negedge clk);
    // Initial state after start-up: code 000 with zero operands (R2)
    check("R2", {4'h0, y4}, 8'h0F);
    check("R2", y8, 8'hFF);
    // R1: widths
    check("R1", W8'($bits(y4)), W8'(W4));
    check("R1", W8'($bits(y8)), W8'(W8));

    // Exhaustive sweep at WIDTH=4 (R2..R9, R11)
    for (int op = 0; op < 8; op++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          s4 = 3'(op); a4 = 4'(ia); b4 = 4'(ib);
          #1;
          check(req_of(3'(op)), {4'h0, y4},
                {4'h0, ref_fn(3'(op), {4'h0, a4}, {4'h0, b4})[3:0]});
        end
      end
      @(negedge clk);
    end

    // R11: code-to-function index with bit 2 as MSB, via distinct patterns
    a8 = 8'b1100_1010; b8 = 8'b1010_0110;
    for (int op = 0; op < 8; op++) begin
      s8 = 3'(op); #1;
      check("R11", y8, ref_fn(3'(op), a8, b8));
    end

    // Corners at WIDTH=8
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 4; c++) begin
        s8 = 3'(op);
        a8 = c[0] ? 8'hFF : 8'h00;
        b8 = c[1] ? 8'hFF : 8'h00;
        #1;
        check(req_of(3'(op)), y8, ref_fn(3'(op), a8, b8));
      end
    end

    // R10: walking single bit under OR
    s8 = 3'd1; b8 = '0;
    for (int j = 0; j < W8; j++) begin
      a8 = 8'(1) << j; #1;
      check("R10", y8, 8'(1) << j);
    end
    // R10: walking zero under AND with the other operand all ones
    s8 = 3'd5; b8 = 8'hFF;
    for (int j = 0; j < W8; j++) begin
      a8 = ~(8'(1) << j); #1;
      check("R10", y8, ~(8'(1) << j));
    end

    // Pseudo-random operands
    lfsr = 8'hA5;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      a8 = lfsr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      b8 = lfsr ^ 8'h3C;
      s8 = 3'(n % 8);
      #1;
      check(req_of(s8), y8, ref_fn(s8, a8, b8));
      if (n % 16 == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule